// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Bus Controller

This block is the bus-facing half of a serial memory slave on a two-wire, open-drain bus. It oversamples the clock and data lines with the system clock and finds bus start and stop conditions. It shifts in bytes most significant bit first and matches the select byte against two device-type codes and a three-bit strap address. For each transfer it addresses, it pulls the data line low in the acknowledge slot. Bytes received in write direction are handed to the memory core on a byte-wide strobe port, tagged with the address space (storage array or protection settings) and marked when they are the first byte after the select byte.

In read direction the block asks the core for a byte with a one-cycle request. It samples the byte input at the next SCL falling edge and shifts it out. A master acknowledge asks for one more byte. A master not-acknowledge puts the block in standby until the next start or stop. A stop that ends a write transfer which carried at least one byte raises a one-cycle commit pulse, which starts the internal programming cycle. While the core reports that cycle as busy, the controller ignores the bus completely. Any start, including one in the middle of a byte, drops the current byte and begins a new select byte. The system clock must run at least eight times faster than SCL.

Top module: `i2c_mem_slave_fe`

States: IDLE (waiting for a start), SEL (shifting the select byte), SEL_ACK (select acknowledge slot), WR_BYTE / WR_ACK (receiving a write byte and acknowledging it), RD_BYTE / RD_ACK (shifting out a read byte and sampling the master's answer), STANDBY (after a master not-acknowledge). Transitions: any state goes to SEL on a start, to IDLE on a stop or while busy is high. SEL goes to SEL_ACK on a match and to IDLE on a mismatch. SEL_ACK goes to RD_BYTE or WR_BYTE according to the direction bit. WR_BYTE and WR_ACK alternate. RD_ACK goes to RD_BYTE on a master acknowledge and to STANDBY on a not-acknowledge.

## Requirements
- R1: After reset sda_pull, rx_valid, rd_req and wr_commit are all low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, bytes clocked without a new start are not acknowledged.
- R3: The select byte holds the type code in bits 7:4, the slave address in bits 3:1 and the direction in bit 0 (1 = read). Type 1010b selects the storage array (space_prot = 0) and type 0110b selects the protection settings (space_prot = 1). The block acknowledges only if bits 3:1 equal strap_addr. Any other select byte gets no acknowledge, and later bytes up to the next start are ignored.
- R4: In a write transfer each received byte (MSB first, SDA sampled on SCL rising) appears on rx_data with a one-cycle rx_valid. rx_first is 1 only for the first byte after the select byte. Each byte is acknowledged.
- R5: A stop after a write transfer that carried at least one byte gives exactly one one-cycle wr_commit, with space_prot showing the selected space. A stop right after the select byte gives no commit, and neither does a transfer ended by a repeated start.
- R6: While busy is high the block ignores start, stop and data: no acknowledge, no rx_valid, no commit.
- R7: In a read transfer, rd_req pulses once for each byte needed. The byte on rd_data is sampled at the next SCL fall and shifted out MSB first, changing after SCL falling edges. A master acknowledge asks for one more byte. A not-acknowledge releases SDA until the next start or stop.
- R8: A start in the middle of a byte drops that byte and starts a new select byte.
- R9: sda_pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | When high, the data line is pulled low |
| strap_addr | input | 3 | Strapped slave address |
| busy | input | 1 | Internal programming cycle in progress |
| rx_valid | output | 1 | One-cycle strobe for a received write byte |
| rx_data | output | 8 | Received byte |
| rx_first | output | 1 | Byte is the first after the select byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte from the memory core |
| wr_commit | output | 1 | One-cycle pulse that starts the programming cycle |
| space_prot | output | 1 | Selected space: 0 storage array, 1 protection settings |

## Verification
A wrong controller state shows on the bus at the next acknowledge slot. The master sees a missing or extra pull-low on the ninth clock of the byte, at most nine SCL periods after the fault. A lost bit count or a wrong first-byte flag shows on rx_data or rx_first at the same byte boundary. A stale write-done record shows as a missing or extra wr_commit within a few system cycles of the stop. A read fault shows as a wrong bit at the next SCL rising edge, or as a wrong number of rd_req pulses.

// File: rtl/smf_pkg.sv
package smf_pkg;
    localparam int BYTE_W     = 8;
    localparam int BIT_CNT_W  = $clog2(BYTE_W);
    localparam int SEL_TYPE_W = 4;
    localparam int SEL_ADDR_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_STANDBY
    } smf_state_e;
endpackage

// File: rtl/smf_line_sync.sv
module smf_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;
    logic              scl_now;

    // Synchronizer chains reset to the idle (released) bus level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_now   = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign bus_start = scl_now & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_now & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smf_sel_decode.sv
module smf_sel_decode
    import smf_pkg::*;
#(
    parameter logic [SEL_TYPE_W-1:0] TYPE_MEM  = 4'b1010,
    parameter logic [SEL_TYPE_W-1:0] TYPE_PROT = 4'b0110
) (
    input  logic [BYTE_W-1:0]     sel_byte,
    input  logic [SEL_ADDR_W-1:0] strap_addr,
    output logic                  dec_hit,
    output logic                  dec_prot,
    output logic                  dec_read
);
    logic [SEL_TYPE_W-1:0] type_code;
    logic [SEL_ADDR_W-1:0] addr_code;
    logic                  is_mem, is_prot;

    assign type_code = sel_byte[BYTE_W-1 -: SEL_TYPE_W];
    assign addr_code = sel_byte[SEL_ADDR_W:1];
    assign is_mem    = (type_code == TYPE_MEM);
    assign is_prot   = (type_code == TYPE_PROT);
    assign dec_hit   = (is_mem | is_prot) & (addr_code == strap_addr);
    assign dec_prot  = is_prot;
    assign dec_read  = sel_byte[0];
endmodule

// File: rtl/smf_ctrl.sv
module smf_ctrl
    import smf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              dec_hit,
    input  logic              dec_prot,
    input  logic              dec_read,
    output logic [BYTE_W-1:0] sel_byte,
    output logic              sda_pull,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_first,
    output logic              rd_req,
    output logic              wr_commit,
    output logic              space_prot
);
    smf_state_e           state_q, state_d;
    logic [BYTE_W-1:0]    shreg_q;
    logic [BIT_CNT_W-1:0] cnt_q;
    logic                 seen_q;    // acknowledge slot: SCL rise already seen
    logic                 dir_rd_q;
    logic                 first_q;
    logic                 wrote_q;
    logic                 mack_q;
    logic                 last_bit;

    assign last_bit = (cnt_q == BIT_CNT_W'(BYTE_W - 1));
    assign sel_byte = {shreg_q[BYTE_W-2:0], sda_s};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_SEL;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_STANDBY: state_d = state_q;
                ST_SEL: begin
                    if (scl_rise && last_bit) state_d = dec_hit ? ST_SEL_ACK : ST_IDLE;
                end
                ST_SEL_ACK: begin
                    if (scl_fall && seen_q) state_d = dir_rd_q ? ST_RD_BYTE : ST_WR_BYTE;
                end
                ST_WR_BYTE: begin
                    if (scl_rise && last_bit) state_d = ST_WR_ACK;
                end
                ST_WR_ACK: begin
                    if (scl_fall && seen_q) state_d = ST_WR_BYTE;
                end
                ST_RD_BYTE: begin
                    if (scl_rise && last_bit) state_d = ST_RD_ACK;
                end
                ST_RD_ACK: begin
                    if (scl_fall && seen_q) state_d = mack_q ? ST_RD_BYTE : ST_STANDBY;
                end
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            seen_q     <= 1'b0;
            dir_rd_q   <= 1'b0;
            first_q    <= 1'b0;
            wrote_q    <= 1'b0;
            mack_q     <= 1'b0;
            sda_pull   <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_first   <= 1'b0;
            rd_req     <= 1'b0;
            wr_commit  <= 1'b0;
            space_prot <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            rd_req    <= 1'b0;
            wr_commit <= 1'b0;
            if (busy) begin
                sda_pull <= 1'b0;
                seen_q   <= 1'b0;
            end else if (bus_start) begin
                sda_pull <= 1'b0;
                cnt_q    <= '0;
                seen_q   <= 1'b0;
                wrote_q  <= 1'b0;
            end else if (bus_stop) begin
                sda_pull  <= 1'b0;
                seen_q    <= 1'b0;
                wr_commit <= wrote_q;
                wrote_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE, ST_STANDBY: sda_pull <= 1'b0;
                    ST_SEL: begin
                        if (scl_rise) begin
                            shreg_q <= sel_byte;
                            cnt_q   <= cnt_q + 1'b1;
                            if (last_bit) begin
                                space_prot <= dec_prot;
                                dir_rd_q   <= dec_read;
                                first_q    <= 1'b1;
                                seen_q     <= 1'b0;
                            end
                        end
                    end
                    ST_SEL_ACK, ST_WR_ACK: begin
                        if (scl_fall && !seen_q) begin
                            sda_pull <= 1'b1;
                        end else if (scl_rise) begin
                            seen_q <= 1'b1;
                            if (state_q == ST_SEL_ACK && dir_rd_q) rd_req <= 1'b1;
                        end else if (scl_fall) begin
                            seen_q <= 1'b0;
                            cnt_q  <= '0;
                            if (state_q == ST_SEL_ACK && dir_rd_q) begin
                                shreg_q  <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg_q <= sel_byte;
                            cnt_q   <= cnt_q + 1'b1;
                            if (last_bit) begin
                                rx_valid <= 1'b1;
                                rx_data  <= sel_byte;
                                rx_first <= first_q;
                                first_q  <= 1'b0;
                                wrote_q  <= 1'b1;
                                seen_q   <= 1'b0;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                            cnt_q   <= cnt_q + 1'b1;
                            if (last_bit) seen_q <= 1'b0;
                        end else if (scl_fall) begin
                            sda_pull <= ~shreg_q[BYTE_W-1];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_fall && !seen_q) begin
                            sda_pull <= 1'b0;
                        end else if (scl_rise) begin
                            seen_q <= 1'b1;
                            mack_q <= ~sda_s;
                            if (!sda_s) rd_req <= 1'b1;
                        end else if (scl_fall) begin
                            seen_q <= 1'b0;
                            cnt_q  <= '0;
                            if (mack_q) begin
                                shreg_q  <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_mem_slave_fe.sv
module i2c_mem_slave_fe
    import smf_pkg::*;
#(
    parameter int                    SYNC_STAGES = 2,
    parameter logic [SEL_TYPE_W-1:0] TYPE_MEM    = 4'b1010,
    parameter logic [SEL_TYPE_W-1:0] TYPE_PROT   = 4'b0110
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull,
    input  logic [SEL_ADDR_W-1:0] strap_addr,
    input  logic                  busy,
    output logic                  rx_valid,
    output logic [BYTE_W-1:0]     rx_data,
    output logic                  rx_first,
    output logic                  rd_req,
    input  logic [BYTE_W-1:0]     rd_data,
    output logic                  wr_commit,
    output logic                  space_prot
);
    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [BYTE_W-1:0] sel_byte;
    logic              dec_hit, dec_prot, dec_read;

    smf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    smf_sel_decode #(.TYPE_MEM(TYPE_MEM), .TYPE_PROT(TYPE_PROT)) u_dec (
        .sel_byte   (sel_byte),
        .strap_addr (strap_addr),
        .dec_hit    (dec_hit),
        .dec_prot   (dec_prot),
        .dec_read   (dec_read)
    );

    smf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .busy       (busy),
        .rd_data    (rd_data),
        .dec_hit    (dec_hit),
        .dec_prot   (dec_prot),
        .dec_read   (dec_read),
        .sel_byte   (sel_byte),
        .sda_pull   (sda_pull),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_first   (rx_first),
        .rd_req     (rd_req),
        .wr_commit  (wr_commit),
        .space_prot (space_prot)
    );
endmodule

// File: rtl/smf_checker.sv
module smf_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic busy,
    input logic sda_pull,
    input logic rx_valid,
    input logic wr_commit,
    input logic rd_req
);
    // R4: the received-byte strobe lasts a single cycle
    a_r4_rx_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: the commit pulse lasts a single cycle and never coincides with a byte strobe
    a_r5_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
    a_r5_commit_not_rx: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !rx_valid);

    // R6: a busy core keeps the bus released and the byte port quiet
    a_r6_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!sda_pull && !rx_valid && !wr_commit));

    // R7: one request pulse per byte
    a_r7_rdreq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R9: the pull-low enable moves only while the clock line is low
    a_r9_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(busy)) |-> !scl_in);
endmodule

bind i2c_mem_slave_fe smf_checker u_smf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .busy      (busy),
    .sda_pull  (sda_pull),
    .rx_valid  (rx_valid),
    .wr_commit (wr_commit),
    .rd_req    (rd_req)
);

// File: tb/i2c_mem_slave_fe_bench.sv
module i2c_mem_slave_fe_bench;
    localparam int Q = 5;                 // quarter SCL period in clocks
    localparam logic [2:0] STRAP = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       sda_pull, rx_valid, rx_first, rd_req, wr_commit, space_prot;
    logic [7:0] rx_data;
    wire        sda_in = m_sda & ~sda_pull;

    always #4 clk = ~clk;                 // 125 MHz

    i2c_mem_slave_fe u_i2c_mem_slave_fe (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_in), .sda_pull(sda_pull),
        .strap_addr(STRAP), .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_first(rx_first), .rd_req(rd_req), .rd_data(rd_data),
        .wr_commit(wr_commit), .space_prot(space_prot));

    int n_chk = 0, n_err = 0;
    int n_commit = 0, last_commit_space = 0, rptr = 0, bad_pull = 0;
    logic [9:0] exp_rx[$];               // {first, space, data}
    logic [7:0] rmem[16];
    logic       prev_pull = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model, evaluated every clock away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (exp_rx.size() == 0) chk(1'b0, "R4 unexpected rx byte", rx_data, 0);
                else begin
                    logic [9:0] e;
                    e = exp_rx.pop_front();
                    chk({rx_first, space_prot, rx_data} == e, "R4 rx first/space/data",
                        {rx_first, space_prot, rx_data}, e);
                end
            end
            if (wr_commit) begin
                n_commit++;
                last_commit_space = space_prot;
            end
            if (rd_req) begin
                rd_data <= rmem[rptr % 16];
                rptr++;
            end
            if (sda_pull != prev_pull && m_scl) bad_pull++;
            prev_pull = sda_pull;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda_in; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~mack);
    endtask

    localparam logic [7:0] SEL_MEM_W  = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_MEM_R  = {4'b1010, STRAP, 1'b1};
    localparam logic [7:0] SEL_PROT_W = {4'b0110, STRAP, 1'b0};

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int c0, r0;
        for (int i = 0; i < 16; i++) rmem[i] = 8'h3C ^ 8'(i * 17);
        wq(5);
        // R1 reset state
        chk(!sda_pull && !rx_valid && !rd_req && !wr_commit, "R1 reset outputs",
            {sda_pull, rx_valid, rd_req, wr_commit}, 0);
        rst_n = 1'b1;
        wq(10);

        // R3/R4/R5 write to storage array
        c0 = n_commit;
        bus_start();
        send_byte(SEL_MEM_W, ack); chk(ack, "R3 select storage write ack", ack, 1);
        exp_rx.push_back({1'b1, 1'b0, 8'h12});
        send_byte(8'h12, ack); chk(ack, "R4 address byte ack", ack, 1);
        exp_rx.push_back({1'b0, 1'b0, 8'h34});
        send_byte(8'h34, ack); chk(ack, "R4 data byte ack", ack, 1);
        exp_rx.push_back({1'b0, 1'b0, 8'hA5});
        send_byte(8'hA5, ack); chk(ack, "R4 data byte ack", ack, 1);
        bus_stop(); wq(10);
        chk(n_commit - c0 == 1, "R5 one commit after write", n_commit - c0, 1);
        chk(last_commit_space == 0, "R5 commit space storage", last_commit_space, 0);
        chk(exp_rx.size() == 0, "R4 all bytes delivered", exp_rx.size(), 0);

        // R5 select only, then stop: no commit
        c0 = n_commit;
        bus_start();
        send_byte(SEL_MEM_W, ack); chk(ack, "R3 select ack", ack, 1);
        bus_stop(); wq(10);
        chk(n_commit == c0, "R5 no commit without data", n_commit - c0, 0);

        // R3 wrong type code and wrong strap address
        bus_start();
        send_byte({4'b0101, STRAP, 1'b0}, ack); chk(!ack, "R3 unknown type no ack", ack, 0);
        send_byte(8'h00, ack); chk(!ack, "R3 ignored after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1010, ~STRAP, 1'b0}, ack); chk(!ack, "R3 strap mismatch no ack", ack, 0);
        bus_stop(); wq(10);

        // R3/R5 protection space write
        c0 = n_commit;
        bus_start();
        send_byte(SEL_PROT_W, ack); chk(ack, "R3 select protection ack", ack, 1);
        exp_rx.push_back({1'b1, 1'b1, 8'h01});
        send_byte(8'h01, ack); chk(ack, "R4 protection byte ack", ack, 1);
        bus_stop(); wq(10);
        chk(n_commit - c0 == 1, "R5 commit protection", n_commit - c0, 1);
        chk(last_commit_space == 1, "R5 commit space protection", last_commit_space, 1);

        // R6 busy core ignores the bus
        c0 = n_commit;
        busy = 1'b1;
        bus_start();
        send_byte(SEL_MEM_W, ack); chk(!ack, "R6 busy no ack", ack, 0);
        send_byte(8'h55, ack); chk(!ack, "R6 busy data no ack", ack, 0);
        bus_stop(); wq(10);
        chk(n_commit == c0, "R6 busy no commit", n_commit - c0, 0);
        busy = 1'b0;
        wq(10);

        // R7/R5 random read: address write, repeated start, read three bytes
        c0 = n_commit;
        r0 = rptr;
        bus_start();
        send_byte(SEL_MEM_W, ack); chk(ack, "R7 select write ack", ack, 1);
        exp_rx.push_back({1'b1, 1'b0, 8'h05});
        send_byte(8'h05, ack); chk(ack, "R7 address ack", ack, 1);
        bus_start();
        send_byte(SEL_MEM_R, ack); chk(ack, "R7 select read ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            read_byte(v, k < 2);
            chk(v == rmem[(r0 + k) % 16], "R7 read byte", v, rmem[(r0 + k) % 16]);
        end
        chk(rptr - r0 == 3, "R7 request count", rptr - r0, 3);
        chk(!sda_pull, "R7 released after nack", sda_pull, 0);
        bus_stop(); wq(10);
        chk(n_commit == c0, "R5 no commit after repeated start", n_commit - c0, 0);

        // R2 bytes without a start after stop are not acknowledged
        send_byte(SEL_MEM_W, ack); chk(!ack, "R2 no start no ack", ack, 0);
        bus_stop(); wq(10);

        // R8 repeated start inside a byte
        c0 = n_commit;
        bus_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        send_byte(SEL_MEM_W, ack); chk(ack, "R8 select after mid-byte start", ack, 1);
        exp_rx.push_back({1'b1, 1'b0, 8'h77});
        send_byte(8'h77, ack); chk(ack, "R8 byte after restart", ack, 1);
        bus_stop(); wq(10);
        chk(n_commit - c0 == 1, "R8 commit after restart", n_commit - c0, 1);
        chk(exp_rx.size() == 0, "R4 queue drained", exp_rx.size(), 0);

        // R9 pull-low changes seen only with SCL low
        chk(bad_pull == 0, "R9 pull changes with SCL high", bad_pull, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule